// File: doc/BRIEF.md
# Directional Block Copy Engine

This block copies a run of elements from one region of a byte-addressed memory to another. A start command loads five settings: a source pointer, a destination pointer, an element count, an element size (one byte or one 16-bit word) and a direction. For each element the engine reads at the source pointer, writes that data at the destination pointer, moves both pointers by one element in the chosen direction and lowers the count by one. The run ends when the count reaches zero.

The engine drives a single-port synchronous memory whose read data arrive one cycle after the read request. Every element therefore takes two cycles: a read cycle, then a write cycle. The live pointer and count values are visible on output ports at all times, together with a busy flag and a done flag. The engine has no flags or status of its own that a copy modifies, beyond busy and done.

Top module: `blkcopy_engine`

## Requirements
- R1: After reset, busy and done are 0, cur_src, cur_dst and cur_cnt are 0, and mem_rd and mem_wr are 0.
- R2: A start pulse seen while busy is 0 loads the settings into cur_src, cur_dst and cur_cnt on that clock edge and clears done. With a nonzero count, busy is 1 from the next cycle on.
- R3: Each element uses exactly two cycles. The first is a read cycle (mem_rd=1, mem_addr=cur_src). The second is a write cycle (mem_wr=1, mem_addr=cur_dst), and its mem_wdata is the data the memory returned for that read. mem_rd and mem_wr are never 1 in the same cycle.
- R4: With cfg_down=0, both pointers increase by the element size after every write cycle.
- R5: With cfg_down=1, both pointers decrease by the element size after every write cycle, so the copy runs from high addresses toward low. Pointers wrap modulo 2^ADDR_W.
- R6: With cfg_wide=1, mem_wide is 1, all 16 data bits move and the step is 2. With cfg_wide=0, mem_wide is 0, only bits 7:0 move, mem_wdata[15:8] is 0 and the step is 1.
- R7: cur_cnt drops by one after every write cycle. When it reaches 0, busy falls and done rises on the same edge, and no further memory access occurs.
- R8: A start with cfg_cnt=0 sets done on the next edge, keeps busy at 0 and makes no memory access.
- R9: While busy is 1 a start pulse is ignored. After completion, cur_src, cur_dst, cur_cnt and done keep their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse; accepted only when idle |
| cfg_src | input | ADDR_W | First source byte address |
| cfg_dst | input | ADDR_W | First destination byte address |
| cfg_cnt | input | CNT_W | Number of elements to copy |
| cfg_wide | input | 1 | 1: 16-bit elements, 0: byte elements |
| cfg_down | input | 1 | 1: pointers decrease, 0: pointers increase |
| busy | output | 1 | Copy in progress |
| done | output | 1 | Last copy finished; held until next start |
| cur_src | output | ADDR_W | Live source pointer |
| cur_dst | output | ADDR_W | Live destination pointer |
| cur_cnt | output | CNT_W | Live remaining element count |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wide | output | 1 | Access size: 1 for 16 bits, 0 for 8 bits |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid one cycle after mem_rd |

## Verification
A corrupted pointer shows up at the next memory access. The read or write address then differs from the one the scoreboard predicts, and this happens within two cycles. A wrong step or direction shows in the same way, and it also leaves the final pointers off. A corrupted count makes the run end early or late, and done is seen rising in the wrong cycle. A stray write-data path shows as a data mismatch on the very write cycle that carries it.

// File: rtl/blkcopy_engine.sv
module blkcopy_engine #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] cfg_src,
  input  logic [ADDR_W-1:0] cfg_dst,
  input  logic [CNT_W-1:0]  cfg_cnt,
  input  logic              cfg_wide,
  input  logic              cfg_down,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] cur_src,
  output logic [ADDR_W-1:0] cur_dst,
  output logic [CNT_W-1:0]  cur_cnt,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wide,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  st_t               st;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              wide_q, down_q, done_q;

  wire [ADDR_W-1:0] step   = wide_q ? ADDR_W'(2) : ADDR_W'(1);
  wire [ADDR_W-1:0] src_nx = down_q ? src_q - step : src_q + step;
  wire [ADDR_W-1:0] dst_nx = down_q ? dst_q - step : dst_q + step;
  wire              accept = start && (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      wide_q <= 1'b0;
      down_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          src_q  <= cfg_src;
          dst_q  <= cfg_dst;
          cnt_q  <= cfg_cnt;
          wide_q <= cfg_wide;
          down_q <= cfg_down;
          done_q <= (cfg_cnt == '0);
          st     <= (cfg_cnt == '0) ? S_IDLE : S_RD;
        end
        S_RD: st <= S_WR;
        S_WR: begin
          src_q <= src_nx;
          dst_q <= dst_nx;
          cnt_q <= cnt_q - CNT_W'(1);
          if (cnt_q == CNT_W'(1)) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            st <= S_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign done      = done_q;
  assign cur_src   = src_q;
  assign cur_dst   = dst_q;
  assign cur_cnt   = cnt_q;
  assign mem_rd    = (st == S_RD);
  assign mem_wr    = (st == S_WR);
  assign mem_addr  = mem_wr ? dst_q : src_q;
  assign mem_wide  = wide_q;
  assign mem_wdata = wide_q ? mem_rdata : {8'h00, mem_rdata[7:0]};
endmodule

// File: rtl/blkcopy_engine_chk.sv
module blkcopy_engine_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [CNT_W-1:0]  cfg_cnt,
  input logic              busy,
  input logic              done,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              wide_q,
  input logic              down_q,
  input logic [ADDR_W-1:0] cur_src,
  input logic [ADDR_W-1:0] cur_dst,
  input logic [CNT_W-1:0]  cur_cnt
);
  a_r3_no_rd_wr_together: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  a_r3_wr_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> mem_wr);

  a_r4_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !down_q) |=> (cur_src == $past(cur_src) + (wide_q ? ADDR_W'(2) : ADDR_W'(1))));

  a_r5_down_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && down_q) |=> (cur_dst == $past(cur_dst) - (wide_q ? ADDR_W'(2) : ADDR_W'(1))));

  a_r7_count_dec: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> (cur_cnt == $past(cur_cnt) - CNT_W'(1)));

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !mem_rd && !mem_wr));

  a_r8_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && cfg_cnt == '0) |=> (done && !busy));

  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(cur_src) && $stable(cur_dst) && $stable(cur_cnt) && $stable(done)));
endmodule

bind blkcopy_engine blkcopy_engine_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cfg_cnt(cfg_cnt), .busy(busy),
  .done(done), .mem_rd(mem_rd), .mem_wr(mem_wr), .wide_q(wide_q), .down_q(down_q),
  .cur_src(cur_src), .cur_dst(cur_dst), .cur_cnt(cur_cnt)
);

// File: tb/blkcopy_engine_bench.sv
`timescale 1ns/1ps
module blkcopy_engine_bench;
  localparam int AW = 16;
  localparam int CW = 16;

  logic clk = 0, rst_n = 0, start = 0, cfg_wide = 0, cfg_down = 0;
  logic [AW-1:0] cfg_src = '0, cfg_dst = '0;
  logic [CW-1:0] cfg_cnt = '0;
  logic busy, done, mem_rd, mem_wr, mem_wide;
  logic [AW-1:0] cur_src, cur_dst, mem_addr;
  logic [CW-1:0] cur_cnt;
  logic [15:0] mem_wdata, mem_rdata;

  int checks = 0, failures = 0, accesses = 0;
  logic [7:0] mem [0:1023];
  logic [15:0] exp_rd_q[$];
  logic [31:0] exp_wr_q[$];

  always #10 clk = ~clk;

  blkcopy_engine u_blkcopy_engine (.*);

  function automatic logic [9:0] ix(input logic [AW-1:0] a);
    return a[9:0];
  endfunction

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem_wide ? {mem[ix(mem_addr + 16'd1)], mem[ix(mem_addr)]}
                                      : {8'hA5, mem[ix(mem_addr)]};
    if (mem_wr) begin
      mem[ix(mem_addr)] <= mem_wdata[7:0];
      if (mem_wide) mem[ix(mem_addr + 16'd1)] <= mem_wdata[15:8];
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (mem_rd && mem_wr) check(0, "R3 rd/wr overlap", 32'd1, 32'd0);
    if (mem_rd || mem_wr) accesses++;
    if (mem_rd) begin
      if (exp_rd_q.size() == 0) check(0, "R3 unexpected read", {16'd0, mem_addr}, 32'd0);
      else begin
        logic [15:0] e;
        e = exp_rd_q.pop_front();
        check(mem_addr == e, "R3/R4/R5 read address", {16'd0, mem_addr}, {16'd0, e});
      end
    end
    if (mem_wr) begin
      if (exp_wr_q.size() == 0) check(0, "R3 unexpected write", {mem_addr, mem_wdata}, 32'd0);
      else begin
        logic [31:0] e;
        e = exp_wr_q.pop_front();
        check({mem_addr, mem_wdata} == e, "R3/R6 write addr+data", {mem_addr, mem_wdata}, e);
      end
    end
  end

  task automatic pulse_start(input logic [AW-1:0] s, input logic [AW-1:0] d,
                             input logic [CW-1:0] n, input bit w, input bit dn);
    @(negedge clk);
    cfg_src = s; cfg_dst = d; cfg_cnt = n; cfg_wide = w; cfg_down = dn; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done(input int limit);
    int t = 0;
    while (!done && t < limit) begin @(negedge clk); t++; end
    check(done, "R7 completion timeout", 32'd0, 32'd1);
  endtask

  task automatic run_job(input logic [AW-1:0] s, input logic [AW-1:0] d,
                         input logic [CW-1:0] n, input bit w, input bit dn, input string tag);
    logic [AW-1:0] step, ps, pd;
    logic [15:0] data;
    step = w ? 16'd2 : 16'd1;
    ps = s; pd = d;
    for (int i = 0; i < n; i++) begin
      data = w ? {mem[ix(ps + 16'd1)], mem[ix(ps)]} : {8'h00, mem[ix(ps)]};
      exp_rd_q.push_back(ps);
      exp_wr_q.push_back({pd, data});
      ps = dn ? ps - step : ps + step;
      pd = dn ? pd - step : pd + step;
    end
    pulse_start(s, d, n, w, dn);
    check(busy && !done, {tag, " R2 busy after start"}, {busy, done}, 32'b10);
    check(cur_cnt == n, {tag, " R2 count loaded"}, cur_cnt, n);
    wait_done(4 * n + 10);
    check(!busy, {tag, " R7 idle at end"}, busy, 0);
    check(cur_cnt == 0, {tag, " R7 count zero"}, cur_cnt, 0);
    check(cur_src == ps, {tag, " R4/R5 final src"}, cur_src, ps);
    check(cur_dst == pd, {tag, " R4/R5 final dst"}, cur_dst, pd);
    check(exp_wr_q.size() == 0 && exp_rd_q.size() == 0, {tag, " R3 all accesses seen"},
          exp_wr_q.size(), 0);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int acc0;
    logic [AW-1:0] hs;
    for (int i = 0; i < 1024; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
    repeat (3) @(negedge clk);
    check(!busy && !done, "R1 flags after reset", {busy, done}, 0);
    check(cur_src == 0 && cur_dst == 0 && cur_cnt == 0, "R1 regs after reset", cur_cnt, 0);
    check(!mem_rd && !mem_wr, "R1 no access in reset", {mem_rd, mem_wr}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    run_job(16'h0010, 16'h0100, 16'd6, 0, 0, "R4 byte up");
    run_job(16'h0020, 16'h0200, 16'd4, 1, 0, "R6 word up");
    run_job(16'h005F, 16'h02FF, 16'd5, 0, 1, "R5 byte down");
    run_job(16'h0080, 16'h0380, 16'd3, 1, 1, "R5 word down");
    run_job(16'h0001, 16'hFFF0, 16'd3, 1, 1, "R5 wrap down");
    run_job(16'h0040, 16'h0140, 16'd1, 1, 0, "R7 single");

    acc0 = accesses;
    hs = cur_src;
    pulse_start(16'h0123, 16'h0234, 16'd0, 0, 0);
    check(done && !busy, "R8 zero count done", {busy, done}, 32'b01);
    check(cur_src == 16'h0123 && cur_cnt == 0, "R8 zero count regs", cur_src, 16'h0123);
    repeat (3) @(negedge clk);
    check(accesses == acc0, "R8 no memory access", accesses, acc0);

    exp_rd_q.push_back(16'h0050); exp_wr_q.push_back({16'h0150, 8'h00, mem[ix(16'h0050)]});
    exp_rd_q.push_back(16'h0051); exp_wr_q.push_back({16'h0151, 8'h00, mem[ix(16'h0051)]});
    exp_rd_q.push_back(16'h0052); exp_wr_q.push_back({16'h0152, 8'h00, mem[ix(16'h0052)]});
    pulse_start(16'h0050, 16'h0150, 16'd3, 0, 0);
    @(negedge clk);
    cfg_src = 16'h0300; cfg_dst = 16'h0000; cfg_cnt = 16'd9; cfg_wide = 1; cfg_down = 1; start = 1;
    @(negedge clk);
    start = 0;
    wait_done(40);
    check(cur_src == 16'h0053 && cur_dst == 16'h0153, "R9 start while busy ignored", cur_src, 16'h0053);
    check(exp_wr_q.size() == 0, "R9 only first job ran", exp_wr_q.size(), 0);
    repeat (6) @(negedge clk);
    check(done && cur_src == 16'h0053 && cur_dst == 16'h0153 && cur_cnt == 0,
          "R9 final values held", cur_src, 16'h0053);
    check(mem[ix(16'h0152)] == mem[ix(16'h0052)], "R6 byte stored in memory",
          mem[ix(16'h0152)], mem[ix(16'h0052)]);

    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule